// File: doc/BRIEF.md
# Progressive PAL Sync and Blanking Timer

This block produces the composite sync and blanking timing for a non-interlaced PAL-style frame from an 80 MHz clock. Every timing value is an exact cycle count at that rate. It drives an active-low sync output. It also gives a flag that marks the window where pixels may be shown, the index of the current visible line, and a one-cycle start-of-frame strobe. A pixel source uses that strobe to rewind its read address.

Each frame opens with a vertical interval of sixteen half-lines. Each half-line has a pulse shape picked from a small set. After that come 304 full video lines, which a down-counter tracks. Only 234 of those lines lie inside the framebuffer window. On those lines the active flag opens after the back porch. It closes early enough to leave a minimum front porch before the next line sync. All other lines stay black. When the counter runs out, the vertical interval starts again.

Top module: `pal_sync_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `sync_n`=1, `video_active`=0, `frame_start`=0 and `line_idx`=0. After release the sequence starts at the first half-line of the vertical interval, so the first `frame_start` follows 5 half-lines later.
- R2: Every short-pulse half-line drives `sync_n` low for its first SHORT_CYC cycles (160) and high for the rest of its HALF_CYC cycles (2560). These are the short-short, short-long and short-to-video entries.
- R3: The long-pulse half-lines (long-long and long-short) drive `sync_n` low for all but their final SHORT_CYC cycles, which are high.
- R4: The vertical interval has 16 entries in this order: 5 short-short, 1 short-long, 4 long-long, 1 long-short, 4 short-short, 1 short-to-video. This gives exactly 5 long-pulse half-lines per frame.
- R5: A video line lasts 2*HALF_CYC cycles. `sync_n` is low for the first LSYNC_CYC cycles (320) of the line and high after that.
- R6: After NUM_LINES (304) video lines the vertical interval restarts. The frame period is 16*HALF_CYC + NUM_LINES*2*HALF_CYC cycles.
- R7: Video lines are numbered by a down-counter that runs from NUM_LINES to 1. A line is displayed when the count lies between DISP_FIRST (259) and DISP_LAST (26) inclusive, which gives 234 lines. On a displayed line `line_idx` = DISP_FIRST - count. On every other line it is 0 and `video_active` stays low.
- R8: On a displayed line, `video_active` rises LSYNC_CYC + BACK_CYC cycles after the line starts. BACK_CYC is 640 cycles, or 8 µs.
- R9: `video_active` falls at whichever comes first: ACTIVE_CYC cycles after it rose, or FRONT_CYC cycles (120, or 1.5 µs) before the end of the line.
- R10: `frame_start` is high for exactly one cycle, in the first cycle of the short-long half-line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 80 MHz timing clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | output | 1 | Composite sync, low during a pulse |
| video_active | output | 1 | High inside the picture window of a displayed line |
| line_idx | output | LI_W | Visible line number, 0 at the top |
| frame_start | output | 1 | One-cycle strobe at the start of the short-long half-line |

## Verification
All four outputs are registered once behind the sequencer state. The output for a state therefore appears one edge after that state, and the first output after reset release already shows position zero of the first short-short half-line. The bench samples on the falling edge. It anchors on the first observed `frame_start` and computes every later output from the cycle offset since that strobe. It compares a whole frame cycle by cycle, plus the first cycle of the next frame, so pulse widths, the porch edges and the 304-line period are each checked at their exact cycle. The reset test counts falling edges from release and expects `frame_start` in sample 5*HALF_CYC+1.

// File: rtl/pal_sync_pkg.sv
package pal_sync_pkg;

    localparam int SEQ_LEN = 16;
    localparam int SEQ_W   = $clog2(SEQ_LEN);

    typedef enum logic [2:0] {
        HL_SS,
        HL_SL,
        HL_LL,
        HL_LS,
        HL_SV
    } hl_kind_e;

    // Pulse shape of each vertical half-line slot; order is behaviour.
    function automatic hl_kind_e hl_kind_of(input logic [SEQ_W-1:0] slot);
        if (slot < SEQ_W'(5))        return HL_SS;
        else if (slot == SEQ_W'(5))  return HL_SL;
        else if (slot < SEQ_W'(10))  return HL_LL;
        else if (slot == SEQ_W'(10)) return HL_LS;
        else if (slot < SEQ_W'(15))  return HL_SS;
        else                         return HL_SV;
    endfunction

endpackage

// File: rtl/pal_seq_ctrl.sv
module pal_seq_ctrl
    import pal_sync_pkg::*;
#(
    parameter int HALF_CYC  = 2560,
    parameter int NUM_LINES = 304,
    parameter int POS_W     = 13,
    parameter int LN_W      = 9
) (
    input  logic             clk,
    input  logic             rst,
    output logic             in_video,
    output hl_kind_e         kind,
    output logic [POS_W-1:0] pos,
    output logic [LN_W-1:0]  lcnt
);

    localparam logic [POS_W-1:0] HALF_END = POS_W'(HALF_CYC - 1);
    localparam logic [POS_W-1:0] LINE_END = POS_W'(2 * HALF_CYC - 1);
    localparam logic [SEQ_W-1:0] SLOT_END = SEQ_W'(SEQ_LEN - 1);
    localparam logic [LN_W-1:0]  LN_TOP   = LN_W'(NUM_LINES);

    typedef struct packed {
        logic             in_video;
        logic [SEQ_W-1:0] slot;
        logic [POS_W-1:0] pos;
        logic [LN_W-1:0]  lcnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.in_video) begin
            if (st_q.pos == HALF_END) begin
                st_d.pos = '0;
                if (st_q.slot == SLOT_END) begin
                    st_d.in_video = 1'b1;
                    st_d.slot     = '0;
                    st_d.lcnt     = LN_TOP;
                end else begin
                    st_d.slot = st_q.slot + 1'b1;
                end
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end else begin
            if (st_q.pos == LINE_END) begin
                st_d.pos = '0;
                if (st_q.lcnt == LN_W'(1)) begin
                    st_d.in_video = 1'b0;
                    st_d.slot     = '0;
                    st_d.lcnt     = LN_TOP;
                end else begin
                    st_d.lcnt = st_q.lcnt - 1'b1;
                end
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.in_video <= 1'b0;
            st_q.slot     <= '0;
            st_q.pos      <= '0;
            st_q.lcnt     <= LN_TOP;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_video = st_q.in_video;
    assign kind     = hl_kind_of(st_q.slot);
    assign pos      = st_q.pos;
    assign lcnt     = st_q.lcnt;

endmodule

// File: rtl/pal_sync_shaper.sv
module pal_sync_shaper
    import pal_sync_pkg::*;
#(
    parameter int HALF_CYC   = 2560,
    parameter int SHORT_CYC  = 160,
    parameter int LSYNC_CYC  = 320,
    parameter int BACK_CYC   = 640,
    parameter int FRONT_CYC  = 120,
    parameter int ACTIVE_CYC = 4160,
    parameter int DISP_FIRST = 259,
    parameter int DISP_LAST  = 26,
    parameter int POS_W      = 13,
    parameter int LN_W       = 9,
    parameter int LI_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_video,
    input  hl_kind_e         kind,
    input  logic [POS_W-1:0] pos,
    input  logic [LN_W-1:0]  lcnt,
    output logic             sync_n,
    output logic             video_active,
    output logic [LI_W-1:0]  line_idx,
    output logic             frame_start
);

    localparam int ACT_S     = LSYNC_CYC + BACK_CYC;
    localparam int ACT_E_RAW = ACT_S + ACTIVE_CYC;
    localparam int ACT_E_MAX = 2 * HALF_CYC - FRONT_CYC;
    localparam int ACT_E     = (ACT_E_RAW < ACT_E_MAX) ? ACT_E_RAW : ACT_E_MAX;

    localparam logic [POS_W-1:0] P_SHORT = POS_W'(SHORT_CYC);
    localparam logic [POS_W-1:0] P_LONG  = POS_W'(HALF_CYC - SHORT_CYC);
    localparam logic [POS_W-1:0] P_LSYNC = POS_W'(LSYNC_CYC);
    localparam logic [POS_W-1:0] P_ACT_S = POS_W'(ACT_S);
    localparam logic [POS_W-1:0] P_ACT_E = POS_W'(ACT_E);
    localparam logic [LN_W-1:0]  L_FIRST = LN_W'(DISP_FIRST);
    localparam logic [LN_W-1:0]  L_LAST  = LN_W'(DISP_LAST);

    typedef struct packed {
        logic            sync_n;
        logic            active;
        logic            frame_start;
        logic [LI_W-1:0] line_idx;
    } vout_t;

    vout_t vo_d, vo_q;
    logic            shown;
    logic [LN_W-1:0] row_off;

    always_comb begin
        shown   = in_video && (lcnt <= L_FIRST) && (lcnt >= L_LAST);
        row_off = L_FIRST - lcnt;
        vo_d    = '0;
        if (in_video) begin
            vo_d.sync_n = (pos >= P_LSYNC);
            vo_d.active = shown && (pos >= P_ACT_S) && (pos < P_ACT_E);
            if (shown) begin
                vo_d.line_idx = row_off[LI_W-1:0];
            end
        end else begin
            unique case (kind)
                HL_LL, HL_LS: vo_d.sync_n = (pos >= P_LONG);
                default:      vo_d.sync_n = (pos >= P_SHORT);
            endcase
            vo_d.frame_start = (kind == HL_SL) && (pos == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vo_q        <= '0;
            vo_q.sync_n <= 1'b1;
        end else begin
            vo_q <= vo_d;
        end
    end

    assign sync_n       = vo_q.sync_n;
    assign video_active = vo_q.active;
    assign line_idx     = vo_q.line_idx;
    assign frame_start  = vo_q.frame_start;

endmodule

// File: rtl/pal_sync_gen.sv
module pal_sync_gen
    import pal_sync_pkg::*;
#(
    parameter int HALF_CYC   = 2560,
    parameter int SHORT_CYC  = 160,
    parameter int LSYNC_CYC  = 320,
    parameter int BACK_CYC   = 640,
    parameter int FRONT_CYC  = 120,
    parameter int ACTIVE_CYC = 4160,
    parameter int NUM_LINES  = 304,
    parameter int DISP_FIRST = 259,
    parameter int DISP_LAST  = 26,
    localparam int LI_W      = $clog2(DISP_FIRST - DISP_LAST + 1)
) (
    input  logic            clk,
    input  logic            rst,
    output logic            sync_n,
    output logic            video_active,
    output logic [LI_W-1:0] line_idx,
    output logic            frame_start
);

    localparam int POS_W = $clog2(2 * HALF_CYC);
    localparam int LN_W  = $clog2(NUM_LINES + 1);

    logic             in_video;
    hl_kind_e         kind;
    logic [POS_W-1:0] pos;
    logic [LN_W-1:0]  lcnt;

    pal_seq_ctrl #(
        .HALF_CYC (HALF_CYC),
        .NUM_LINES(NUM_LINES),
        .POS_W    (POS_W),
        .LN_W     (LN_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .in_video(in_video),
        .kind    (kind),
        .pos     (pos),
        .lcnt    (lcnt)
    );

    pal_sync_shaper #(
        .HALF_CYC  (HALF_CYC),
        .SHORT_CYC (SHORT_CYC),
        .LSYNC_CYC (LSYNC_CYC),
        .BACK_CYC  (BACK_CYC),
        .FRONT_CYC (FRONT_CYC),
        .ACTIVE_CYC(ACTIVE_CYC),
        .DISP_FIRST(DISP_FIRST),
        .DISP_LAST (DISP_LAST),
        .POS_W     (POS_W),
        .LN_W      (LN_W),
        .LI_W      (LI_W)
    ) u_shape (
        .clk         (clk),
        .rst         (rst),
        .in_video    (in_video),
        .kind        (kind),
        .pos         (pos),
        .lcnt        (lcnt),
        .sync_n      (sync_n),
        .video_active(video_active),
        .line_idx    (line_idx),
        .frame_start (frame_start)
    );

endmodule

// File: rtl/pal_sync_chk.sv
module pal_sync_chk #(
    parameter int HALF_CYC  = 2560,
    parameter int SHORT_CYC = 160,
    parameter int NUM_DISP  = 234,
    parameter int LI_W      = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            sync_n,
    input logic            video_active,
    input logic [LI_W-1:0] line_idx,
    input logic            frame_start
);

    int unsigned low_run_q;

    always_ff @(posedge clk) begin
        if (rst || sync_n) low_run_q <= 0;
        else               low_run_q <= low_run_q + 1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (sync_n && !video_active && !frame_start && line_idx == '0));

    assert_strobe_in_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> !sync_n);

    assert_long_pulse_bound_R3: assert property (@(posedge clk) disable iff (rst)
        !sync_n |-> (low_run_q < HALF_CYC - SHORT_CYC));

    assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
        video_active |-> (int'(line_idx) < NUM_DISP));

    assert_window_clear_of_sync_R8: assert property (@(posedge clk) disable iff (rst)
        video_active |-> sync_n);

    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

endmodule

bind pal_sync_gen pal_sync_chk #(
    .HALF_CYC (HALF_CYC),
    .SHORT_CYC(SHORT_CYC),
    .NUM_DISP (DISP_FIRST - DISP_LAST + 1),
    .LI_W     (LI_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sync_n      (sync_n),
    .video_active(video_active),
    .line_idx    (line_idx),
    .frame_start (frame_start)
);

// File: tb/tb_pal_sync_gen.sv
module tb_pal_sync_gen;

    localparam int HALF  = 64;
    localparam int LINE  = 2 * HALF;
    localparam int SHORT = 4;
    localparam int LSYNC = 8;
    localparam int BACK  = 16;
    localparam int FRONT = 3;
    localparam int ACT   = 104;
    localparam int NL    = 304;
    localparam int TOP   = 259;
    localparam int BOT   = 26;
    localparam int VS    = 16 * HALF;
    localparam int FRAME = VS + NL * LINE;
    localparam int ACT_S = LSYNC + BACK;
    localparam int ACT_E = (ACT_S + ACT < LINE - FRONT) ? ACT_S + ACT : LINE - FRONT;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_n, video_active, frame_start;
    logic [7:0] line_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pal_sync_gen #(
        .HALF_CYC(HALF), .SHORT_CYC(SHORT), .LSYNC_CYC(LSYNC), .BACK_CYC(BACK),
        .FRONT_CYC(FRONT), .ACTIVE_CYC(ACT), .NUM_LINES(NL),
        .DISP_FIRST(TOP), .DISP_LAST(BOT)
    ) dut (
        .clk(clk), .rst(rst), .sync_n(sync_n), .video_active(video_active),
        .line_idx(line_idx), .frame_start(frame_start)
    );

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_sync(input int s);
        int h, p;
        if (s < VS) begin
            h = s / HALF;
            p = s % HALF;
            if (h >= 6 && h <= 10) return !(p < HALF - SHORT);
            return !(p < SHORT);
        end
        p = (s - VS) % LINE;
        return !(p < LSYNC);
    endfunction

    function automatic int exp_cnt(input int s);
        return NL - (s - VS) / LINE;
    endfunction

    function automatic bit exp_shown(input int s);
        if (s < VS) return 1'b0;
        return exp_cnt(s) <= TOP && exp_cnt(s) >= BOT;
    endfunction

    function automatic bit exp_active(input int s);
        int p;
        p = (s - VS) % LINE;
        return exp_shown(s) && p >= ACT_S && p < ACT_E;
    endfunction

    function automatic int exp_idx(input int s);
        return exp_shown(s) ? TOP - exp_cnt(s) : 0;
    endfunction

    // R1: idle outputs during reset, start point after release
    task automatic t_reset(input int hold);
        int n;
        @(negedge clk);
        rst = 1'b1;
        repeat (hold) @(negedge clk);
        check("R1 sync_n idle", sync_n == 1'b1, sync_n, 1);
        check("R1 active idle", video_active == 1'b0, video_active, 0);
        check("R1 frame_start idle", frame_start == 1'b0, frame_start, 0);
        check("R1 line_idx idle", line_idx == 8'd0, line_idx, 0);
        rst = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) check("R2 first short pulse after release", sync_n == 1'b0, sync_n, 0);
        end while (!frame_start && n < 4 * VS);
        check("R1 strobe after release", n == 5 * HALF + 1, n, 5 * HALF + 1);
    endtask

    // R2..R10: whole frame compared cycle by cycle from the strobe
    task automatic t_frame;
        int s, period, nlong, run, nrows, p;
        int e_r2, e_r3, e_r5, e_r7, e_r8, e_r9, e_r10;
        int a_r2, a_r3, a_r5, a_r7, a_r8, a_r9, a_r10;
        bit prev_act;
        e_r2 = 0; e_r3 = 0; e_r5 = 0; e_r7 = 0; e_r8 = 0; e_r9 = 0; e_r10 = 0;
        a_r2 = 0; a_r3 = 0; a_r5 = 0; a_r7 = 0; a_r8 = 0; a_r9 = 0; a_r10 = 0;
        period = -1; nlong = 0; run = 0; nrows = 0; prev_act = 1'b0;
        while (!frame_start) @(negedge clk);
        s = 5 * HALF;
        for (int k = 0; k <= FRAME; k++) begin
            if (k > 0 && frame_start && period < 0) period = k;
            if (sync_n !== exp_sync(s)) begin
                if (s >= VS) begin e_r5++; a_r5 = sync_n; end
                else if (s / HALF >= 6 && s / HALF <= 10) begin e_r3++; a_r3 = sync_n; end
                else begin e_r2++; a_r2 = sync_n; end
            end
            if (frame_start !== (s == 5 * HALF) && k < FRAME) begin e_r10++; a_r10 = frame_start; end
            if (s >= VS && int'(line_idx) != exp_idx(s)) begin e_r7++; a_r7 = line_idx; end
            if (video_active !== exp_active(s)) begin
                p = (s - VS) % LINE;
                if (p < LINE / 2) begin e_r8++; a_r8 = video_active; end
                else begin e_r9++; a_r9 = video_active; end
            end
            if (!sync_n) run++;
            else begin
                if (run >= HALF / 2 && k < FRAME) nlong++;
                run = 0;
            end
            if (video_active && !prev_act) nrows++;
            prev_act = video_active;
            @(negedge clk);
            s = (s + 1) % FRAME;
        end
        check("R2 short half-line mismatches", e_r2 == 0, a_r2, !a_r2);
        check("R3 long half-line mismatches", e_r3 == 0, a_r3, !a_r3);
        check("R4 long pulses per frame", nlong == 5, nlong, 5);
        check("R5 line sync mismatches", e_r5 == 0, a_r5, !a_r5);
        check("R6 frame period", period == FRAME, period, FRAME);
        check("R7 line_idx mismatches", e_r7 == 0, e_r7, 0);
        check("R7 displayed rows", nrows == TOP - BOT + 1, nrows, TOP - BOT + 1);
        check("R8 window start mismatches", e_r8 == 0, a_r8, !a_r8);
        check("R9 clipped window end mismatches", e_r9 == 0, a_r9, !a_r9);
        check("R10 strobe mismatches", e_r10 == 0, a_r10, !a_r10);
    endtask

    initial begin
        t_reset(4);
        t_frame();
        repeat (3 * LINE + 37) @(negedge clk);
        t_reset(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule